// File: doc/BRIEF.md
# Aggregated Interrupt Status Controller

This block gathers up to 32 level-sensitive interrupt request lines into a single status register and one combined interrupt output for a CPU. A source that goes from low to high, while it is enabled and while nothing else is waiting to be serviced, sets its status bit. The CPU reads the status word, services the sources it finds there, and clears their bits by writing ones. A source that rises while it is masked, or while earlier status is still outstanding, is held in an internal pending set. That set is not visible on the bus. Once servicing finishes, the held requests are moved into status and the output goes high again.

Level-sensitive sources can drop before they are serviced. The pending set is therefore pruned to bits whose line is still high and still enabled. The pruning happens before any move into status and whenever any input line changes level. Without it, the CPU would be handed a request whose device has already withdrawn it.

A build parameter selects when pending bits are moved. In grouped mode the whole pending set moves once a status write leaves status empty. In per-bit mode, clearing a given status bit moves only that source's pending bit. The CPU reaches the block through a word-addressed register bus with combinational read data.

Top module: `irq_agg_ctrl`

## Requirements
- R1: Reset clears the enable register, the status register and the pending set. After reset the interrupt output is low and both registers read back zero.
- R2: Word offset 0 holds the enable register, read/write with one bit per source (bit i is source i). Word offset 1 holds the status register. Reads of any other offset return zero, and writes to them change nothing. An enable write takes effect from the next cycle.
- R3: A low-to-high transition on an enabled source sets that source's status bit in the following cycle, provided the condition in R4 or R11 does not send it to pending. The interrupt output is high exactly when the status register is nonzero.
- R4: In both modes, a rising source whose enable bit is 0 is recorded in the pending set and not in status. In grouped mode, a rising source is also recorded in pending when status already holds any bit.
- R5: The status register is write-1-to-clear: each 1 written at offset 1 clears that bit, each 0 leaves its bit unchanged, and status bits clear through no other path.
- R6: In grouped mode, a status write that leaves status all-zero moves the filtered pending set into status and empties the pending set. If any bit is moved, the interrupt output rises again in the next cycle.
- R7: Immediately before a move into status, the pending set is ANDed with the current source levels and with the enable register, so a bit whose source is low or disabled at that moment is never moved.
- R8: In any cycle where at least one source line differs from its previous level, the pending set is ANDed with the current levels and the enable register. A request dropped this way stays dropped even if its enable is set again later.
- R9: In per-bit mode, writing 1 to status bit i moves only pending bit i, after filtering, into status. Other pending bits remain held.
- R10: A source that is low, or that stays high with no new rising edge, never sets a status or pending bit. A line held high after its status bit is cleared does not set it again.
- R11: In per-bit mode, a rising enabled source goes to status whenever its own status bit is clear, whatever the other status bits hold. If its own bit is set, it goes to pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Level-sensitive interrupt request lines |
| bus_we_i | input | 1 | Register write strobe for this cycle |
| bus_addr_i | input | ADDR_W | Word offset of the register access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt, high while status is nonzero |

## Verification
The hardest situation to reach is a pending request that has gone stale while nothing at the ports shows it. The pending set cannot be read, and a stale bit only shows up later as a status bit that should not have appeared. The stimulus first holds one status bit to keep the controller busy, then raises a second source so that it is parked in pending. It then either drops that source, masks it, or masks it and toggles an unrelated line before enabling it again. Finally it clears status, and the status read-back shows whether the parked request was moved or dropped. A second instance built in per-bit mode is driven so that two sources are pending at once, which confirms that clearing one bit releases only its own request.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Register word offsets decoded by the bus interface
    localparam int unsigned OFF_ENABLE = 0;
    localparam int unsigned OFF_STATUS = 1;

    // When held requests move into status
    typedef enum logic {
        PROMO_GROUP   = 1'b0,  // whole set, once status drains to zero
        PROMO_PER_BIT = 1'b1   // one bit, when its status bit is cleared
    } promo_mode_e;

endpackage

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [N_SRC-1:0]  en_q_i,
    input  logic [N_SRC-1:0]  stat_q_i,
    output logic              en_wr_o,
    output logic [N_SRC-1:0]  en_wdata_o,
    output logic              stat_wr_o,
    output logic [N_SRC-1:0]  stat_clr_o
);

    localparam logic [ADDR_W-1:0] ADDR_EN = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] ADDR_ST = ADDR_W'(OFF_STATUS);

    logic hit_en;
    logic hit_st;

    assign hit_en = (bus_addr_i == ADDR_EN);
    assign hit_st = (bus_addr_i == ADDR_ST);

    always_comb begin
        en_wr_o    = bus_we_i && hit_en;
        stat_wr_o  = bus_we_i && hit_st;
        en_wdata_o = bus_wdata_i[N_SRC-1:0];
        stat_clr_o = stat_wr_o ? bus_wdata_i[N_SRC-1:0] : '0;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (hit_en) begin
            bus_rdata_o[N_SRC-1:0] = en_q_i;
        end else if (hit_st) begin
            bus_rdata_o[N_SRC-1:0] = stat_q_i;
        end
    end

endmodule

// File: rtl/irq_agg_edge.sv
module irq_agg_edge #(
    parameter int unsigned N_SRC = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] src_i,
    output logic [N_SRC-1:0] rise_o,
    output logic             changed_o
);

    logic [N_SRC-1:0] lvl_d;
    logic [N_SRC-1:0] lvl_q;

    always_comb begin
        lvl_d     = src_i;
        rise_o    = src_i & ~lvl_q;
        changed_o = |(src_i ^ lvl_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

endmodule

// File: rtl/irq_agg_core.sv
module irq_agg_core
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC = 32,
    parameter promo_mode_e MODE  = PROMO_GROUP
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] rise_i,
    input  logic             changed_i,
    input  logic             en_wr_i,
    input  logic [N_SRC-1:0] en_wdata_i,
    input  logic             stat_wr_i,
    input  logic [N_SRC-1:0] stat_clr_i,
    output logic [N_SRC-1:0] en_q_o,
    output logic [N_SRC-1:0] stat_q_o,
    output logic [N_SRC-1:0] pend_q_o
);

    typedef struct packed {
        logic [N_SRC-1:0] en;
        logic [N_SRC-1:0] stat;
        logic [N_SRC-1:0] pend;
    } core_state_t;

    core_state_t st_d;
    core_state_t st_q;

    // Pending after the level-change filter, status after the W1C write
    logic [N_SRC-1:0] pend_f;
    logic [N_SRC-1:0] stat_c;
    logic [N_SRC-1:0] live;
    // Variant outputs
    logic [N_SRC-1:0] promo;
    logic [N_SRC-1:0] pend_keep;
    logic [N_SRC-1:0] admit;

    always_comb begin
        pend_f = changed_i ? (st_q.pend & src_i & st_q.en) : st_q.pend;
        stat_c = st_q.stat & ~stat_clr_i;
        live   = pend_f & src_i & st_q.en;
    end

    generate
        if (MODE == PROMO_GROUP) begin : g_group
            logic drained;
            logic busy;
            always_comb begin
                drained   = stat_wr_i && (stat_c == '0);
                promo     = drained ? live : '0;
                pend_keep = drained ? '0 : pend_f;
                busy      = |(stat_c | promo);
                admit     = busy ? '0 : st_q.en;
            end
        end else begin : g_per_bit
            logic any_sel;
            always_comb begin
                any_sel   = |stat_clr_i;
                promo     = stat_clr_i & live;
                pend_keep = any_sel ? (live & ~stat_clr_i) : pend_f;
                admit     = st_q.en & ~(stat_c | promo);
            end
        end
    endgenerate

    always_comb begin
        logic [N_SRC-1:0] to_stat;
        logic [N_SRC-1:0] to_pend;
        st_d    = st_q;
        to_stat = rise_i & admit;
        to_pend = rise_i & ~to_stat;
        st_d.stat = stat_c | promo | to_stat;
        st_d.pend = pend_keep | to_pend;
        if (en_wr_i) begin
            st_d.en = en_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q_o   = st_q.en;
    assign stat_q_o = st_q.stat;
    assign pend_q_o = st_q.pend;

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter promo_mode_e MODE   = PROMO_GROUP
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    logic [N_SRC-1:0] rise;
    logic             changed;
    logic             en_wr;
    logic [N_SRC-1:0] en_wdata;
    logic             stat_wr;
    logic [N_SRC-1:0] stat_clr;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] stat_q;
    logic [N_SRC-1:0] pend_q;

    irq_agg_edge #(.N_SRC(N_SRC)) u_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .src_i     (src_i),
        .rise_o    (rise),
        .changed_o (changed)
    );

    irq_agg_regif #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .en_q_i      (en_q),
        .stat_q_i    (stat_q),
        .en_wr_o     (en_wr),
        .en_wdata_o  (en_wdata),
        .stat_wr_o   (stat_wr),
        .stat_clr_o  (stat_clr)
    );

    irq_agg_core #(.N_SRC(N_SRC), .MODE(MODE)) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (src_i),
        .rise_i     (rise),
        .changed_i  (changed),
        .en_wr_i    (en_wr),
        .en_wdata_i (en_wdata),
        .stat_wr_i  (stat_wr),
        .stat_clr_i (stat_clr),
        .en_q_o     (en_q),
        .stat_q_o   (stat_q),
        .pend_q_o   (pend_q)
    );

    assign irq_o = |stat_q;

endmodule

// File: rtl/irq_agg_ctrl_chk.sv
module irq_agg_ctrl_chk
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [N_SRC-1:0]  src_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              irq_o,
    input logic [N_SRC-1:0]  en_q,
    input logic [N_SRC-1:0]  stat_q,
    input logic [N_SRC-1:0]  pend_q
);

    logic             wr_en_seen;
    logic [N_SRC-1:0] wr_clr_seen;

    assign wr_en_seen  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_ENABLE));
    assign wr_clr_seen = (bus_we_i && (bus_addr_i == ADDR_W'(OFF_STATUS)))
                         ? bus_wdata_i[N_SRC-1:0] : '0;

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!irq_o && (en_q == '0) && (stat_q == '0)));

    // R2
    en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_q != $past(en_q)) |-> $past(wr_en_seen));

    // R5
    stat_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(stat_q) & ~stat_q & ~$past(wr_clr_seen)) == '0));

    // R10
    new_stat_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((stat_q & ~$past(stat_q) & ~($past(src_i) & $past(en_q))) == '0));

    // R10
    new_pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pend_q & ~$past(pend_q) & ~$past(src_i)) == '0));

endmodule

bind irq_agg_ctrl irq_agg_ctrl_chk #(
    .N_SRC (N_SRC),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .en_q        (en_q),
    .stat_q      (stat_q),
    .pend_q      (pend_q)
);

// File: tb/irq_agg_ctrl_test.sv
module irq_agg_ctrl_test;
    import irq_agg_pkg::*;

    localparam int unsigned N  = 32;
    localparam int unsigned AW = 4;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    // grouped-mode instance
    logic [N-1:0]  g_src = '0;
    logic          g_we = 1'b0;
    logic [AW-1:0] g_addr = '0;
    logic [DW-1:0] g_wdata = '0;
    logic [DW-1:0] g_rdata;
    logic          g_irq;
    // per-bit-mode instance
    logic [N-1:0]  p_src = '0;
    logic          p_we = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_wdata = '0;
    logic [DW-1:0] p_rdata;
    logic          p_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    irq_agg_ctrl #(.N_SRC(N), .ADDR_W(AW), .DATA_W(DW), .MODE(PROMO_GROUP)) uut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(g_src), .bus_we_i(g_we),
        .bus_addr_i(g_addr), .bus_wdata_i(g_wdata), .bus_rdata_o(g_rdata),
        .irq_o(g_irq)
    );

    irq_agg_ctrl #(.N_SRC(N), .ADDR_W(AW), .DATA_W(DW), .MODE(PROMO_PER_BIT)) uut_pb (
        .clk_i(clk), .rst_ni(rst_n), .src_i(p_src), .bus_we_i(p_we),
        .bus_addr_i(p_addr), .bus_wdata_i(p_wdata), .bus_rdata_o(p_rdata),
        .irq_o(p_irq)
    );

    typedef struct packed {
        logic [31:0] src;
        logic        we;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_stat;
        logic        exp_irq;
        logic [7:0]  req;
    } vec_t;

    // Grouped mode; offset 0 = enable, 1 = status
    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{32'h00, 1'b1, 4'd0, 32'h0F, 32'h00, 1'b0, 8'd2},  // R2 enable 0..3
        '{32'h01, 1'b0, 4'd0, 32'h00, 32'h01, 1'b1, 8'd3},  // R3
        '{32'h03, 1'b0, 4'd0, 32'h00, 32'h01, 1'b1, 8'd4},  // R4 busy
        '{32'h03, 1'b1, 4'd1, 32'h01, 32'h02, 1'b1, 8'd6},  // R6
        '{32'h03, 1'b1, 4'd1, 32'h02, 32'h00, 1'b0, 8'd10}, // R10 held high
        '{32'h13, 1'b0, 4'd0, 32'h00, 32'h00, 1'b0, 8'd4},  // R4 masked
        '{32'h13, 1'b1, 4'd0, 32'h1F, 32'h00, 1'b0, 8'd4},
        '{32'h17, 1'b0, 4'd0, 32'h00, 32'h04, 1'b1, 8'd3},  // R3
        '{32'h17, 1'b1, 4'd1, 32'h04, 32'h10, 1'b1, 8'd6},  // R6 late enable
        '{32'h17, 1'b1, 4'd1, 32'h10, 32'h00, 1'b0, 8'd5},  // R5
        '{32'h00, 1'b0, 4'd0, 32'h00, 32'h00, 1'b0, 8'd10},
        '{32'h01, 1'b0, 4'd0, 32'h00, 32'h01, 1'b1, 8'd3},
        '{32'h03, 1'b0, 4'd0, 32'h00, 32'h01, 1'b1, 8'd4},
        '{32'h01, 1'b0, 4'd0, 32'h00, 32'h01, 1'b1, 8'd8},  // R8 drop
        '{32'h01, 1'b1, 4'd1, 32'h01, 32'h00, 1'b0, 8'd8},  // R8 not moved
        '{32'h00, 1'b0, 4'd0, 32'h00, 32'h00, 1'b0, 8'd10},
        '{32'h01, 1'b0, 4'd0, 32'h00, 32'h01, 1'b1, 8'd3},
        '{32'h03, 1'b0, 4'd0, 32'h00, 32'h01, 1'b1, 8'd4},
        '{32'h03, 1'b1, 4'd0, 32'h1D, 32'h01, 1'b1, 8'd2},  // mask bit 1
        '{32'h03, 1'b1, 4'd1, 32'h01, 32'h00, 1'b0, 8'd7},  // R7 enable filter
        '{32'h00, 1'b0, 4'd0, 32'h00, 32'h00, 1'b0, 8'd10},
        '{32'h01, 1'b0, 4'd0, 32'h00, 32'h01, 1'b1, 8'd3},
        '{32'h03, 1'b0, 4'd0, 32'h00, 32'h01, 1'b1, 8'd4},
        '{32'h13, 1'b0, 4'd0, 32'h00, 32'h01, 1'b1, 8'd8},  // R8 change drops bit1
        '{32'h13, 1'b1, 4'd0, 32'h1F, 32'h01, 1'b1, 8'd2},
        '{32'h13, 1'b1, 4'd1, 32'h01, 32'h10, 1'b1, 8'd8},  // R8 only bit4 moved
        '{32'h13, 1'b1, 4'd1, 32'h10, 32'h00, 1'b0, 8'd5},
        '{32'h00, 1'b0, 4'd0, 32'h00, 32'h00, 1'b0, 8'd10},
        '{32'h05, 1'b0, 4'd0, 32'h00, 32'h05, 1'b1, 8'd3},
        '{32'h05, 1'b1, 4'd1, 32'h04, 32'h01, 1'b1, 8'd5},  // R5 partial
        '{32'h05, 1'b1, 4'd1, 32'h01, 32'h00, 1'b0, 8'd5}
    };

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, then read status back
    task automatic g_step(input logic [N-1:0] src, input logic we,
                          input logic [AW-1:0] addr, input logic [DW-1:0] wd);
        @(negedge clk);
        g_src = src; g_we = we; g_addr = addr; g_wdata = wd;
        @(posedge clk);
        #2;
        g_we = 1'b0; g_addr = AW'(OFF_STATUS);
        #1;
    endtask

    task automatic p_step(input logic [N-1:0] src, input logic we,
                          input logic [AW-1:0] addr, input logic [DW-1:0] wd);
        @(negedge clk);
        p_src = src; p_we = we; p_addr = addr; p_wdata = wd;
        @(posedge clk);
        #2;
        p_we = 1'b0; p_addr = AW'(OFF_STATUS);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1 values during reset
        #3;
        g_addr = AW'(OFF_ENABLE); #1;
        check("R1", "enable in reset", g_rdata, '0);
        g_addr = AW'(OFF_STATUS); #1;
        check("R1", "status in reset", g_rdata, '0);
        check("R1", "irq in reset", DW'(g_irq), '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 unmapped offsets read zero and ignore writes
        g_step('0, 1'b1, AW'(3), 32'hFFFF_FFFF);
        g_addr = AW'(OFF_ENABLE); #1;
        check("R2", "enable after stray write", g_rdata, '0);
        g_addr = AW'(2); #1;
        check("R2", "unmapped read", g_rdata, '0);
        g_addr = AW'(OFF_STATUS); #1;
        check("R2", "status after stray write", g_rdata, '0);

        // Table walk, grouped mode
        for (int i = 0; i < NV; i++) begin
            g_step(VECS[i].src, VECS[i].we, VECS[i].addr, VECS[i].wdata);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d status", i),
                  g_rdata, VECS[i].exp_stat);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d irq", i),
                  DW'(g_irq), DW'(VECS[i].exp_irq));
        end
        g_addr = AW'(OFF_ENABLE); #1;
        check("R2", "enable readback", g_rdata, 32'h1F);

        // Per-bit mode
        p_step('0, 1'b1, AW'(OFF_ENABLE), 32'h7);
        p_step(32'h1, 1'b0, '0, '0);
        check("R3", "pb first source", p_rdata, 32'h1);
        p_step(32'h3, 1'b0, '0, '0);
        check("R11", "pb second source to status", p_rdata, 32'h3);
        p_step(32'h2, 1'b0, '0, '0);
        p_step(32'h3, 1'b0, '0, '0);
        check("R11", "pb own bit set goes pending", p_rdata, 32'h3);
        p_step(32'h7, 1'b0, '0, '0);
        check("R11", "pb third source", p_rdata, 32'h7);
        p_step(32'h5, 1'b0, '0, '0);
        p_step(32'h7, 1'b0, '0, '0);
        check("R11", "pb bit1 pending", p_rdata, 32'h7);
        p_step(32'h7, 1'b1, AW'(OFF_STATUS), 32'h2);
        check("R9", "pb clear bit1 moves bit1", p_rdata, 32'h7);
        p_step(32'h7, 1'b1, AW'(OFF_STATUS), 32'h4);
        check("R9", "pb clear bit2 leaves bit0 held", p_rdata, 32'h3);
        p_step(32'h7, 1'b1, AW'(OFF_STATUS), 32'h1);
        check("R9", "pb clear bit0 moves bit0", p_rdata, 32'h3);
        p_step(32'h7, 1'b1, AW'(OFF_STATUS), 32'h3);
        check("R9", "pb drained", p_rdata, 32'h0);
        check("R3", "pb irq low", DW'(p_irq), '0);

        // R1 reset again mid-run
        @(negedge clk);
        g_src = 32'h1F;
        rst_n = 1'b0;
        @(posedge clk); #3;
        g_addr = AW'(OFF_ENABLE); #1;
        check("R1", "enable after reset", g_rdata, '0);
        check("R1", "irq after reset", DW'(g_irq), '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule